// File: doc/BRIEF.md
# Transfer Status and Byte Counter

This block is the host-readable status and counting unit of a byte-stream compression engine. The host starts a job with a one-cycle start strobe and gives the job direction (compress or decompress) and, for compression, the number of source bytes to accept. While the job runs, a 16-bit counter tracks bytes on the uncompressed side of the engine. In compression it counts bytes that arrive and stops once the programmed length is reached. In decompression it counts bytes that leave and holds at its top value.

A job ends in one of two ways. An end strobe marks successful completion; for a compression job it also compares the compressed-side byte count, which arrives on an input, against the source count, and records whether the output grew. A non-zero external error vector stops the job without marking it complete. The host reads everything through a combinational read port on a 4-bit address: a status byte, a fixed revision byte, and the two halves of the counter.

Top module: `xfer_stat_unit`

## Requirements
- R1: After the asynchronous reset (rst_n low) or a synchronous soft reset (soft_rst_i high at a clock edge), the status byte reads 0x00 apart from its error bit, and both count bytes read 0x00.
- R2: Address 1 always reads 0xEC, including during and after any reset.
- R3: A start strobe sets busy (status bit 7) at the next edge, clears done (bit 0) and expansion (bit 3), zeroes the count, and latches the direction (comp_mode_i = 1 selects compression) and the programmed length. Busy and done are never both set. A start strobe takes priority over error, end and byte strobes in the same cycle.
- R4: In a compression job, each byte_i strobe while busy adds one to the count while the count is below the programmed length. Strobes arriving once the count equals the length are ignored. rx_full_o is high exactly while a compression job is busy and its count equals the length.
- R5: In a decompression job, each byte_i strobe while busy adds one to the count, and the count holds at 0xFFFF instead of wrapping.
- R6: A job_end_i strobe while busy and with no error clears busy and sets done at the next edge. In compression, expansion is set when comp_cnt_i is greater than the count held at that edge; in decompression it stays clear. A byte strobe in the same cycle is not counted.
- R7: Status bit 1 is the OR of all bits of err_vec_i, combinationally. A non-zero err_vec_i while busy clears busy at the next edge, leaves done clear and holds the count. It overrides end and byte strobes in the same cycle.
- R8: The read map is: address 0 is status {busy, 3'b000, expansion, 1'b0, any-error, done}; address 2 is count bits 15:8; address 3 is count bits 7:0; every other address reads 0x00.
- R9: When no job is busy, byte_i and job_end_i strobes change neither the count nor the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst_i | input | 1 | Synchronous software reset |
| start_i | input | 1 | Start-of-job strobe |
| comp_mode_i | input | 1 | Job direction at start: 1 compress, 0 decompress |
| xfer_len_i | input | 16 | Programmed compression length, latched at start |
| byte_i | input | 1 | One byte moved on the uncompressed side |
| job_end_i | input | 1 | Successful end-of-job strobe |
| comp_cnt_i | input | 16 | Compressed-side byte count, compared at job end |
| err_vec_i | input | ERR_W | Error status bits from the engine |
| rd_addr_i | input | 4 | Register read address |
| rd_data_o | output | 8 | Register read data, combinational |
| rx_full_o | output | 1 | All programmed compression input received |

## Verification
The assertions assume that the strobes are synchronous and one bit each, and that soft_rst_i and start_i are never meant to combine in any way other than soft reset winning. They also assume err_vec_i may be held high across several cycles, so the error rule is stated on the cycle it is seen while busy. The stimulus drives all inputs on the falling edge and keeps the random error vector at zero on most cycles. It keeps programmed lengths small so that compression jobs reach their limit and end with the compressed count on either side of the source count. A directed decompression run of over 65,535 bytes reaches saturation.

// File: rtl/xsu_pkg.sv
package xsu_pkg;

  localparam int CNT_W  = 16;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_STATUS = 4'd0;
  localparam logic [ADDR_W-1:0] A_REV    = 4'd1;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 4'd2;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 4'd3;

  localparam logic [DATA_W-1:0] REV_CODE = 8'b1110_1100;

  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  // True when the counter may still advance.
  function automatic logic cnt_has_room(input logic [CNT_W-1:0] cnt,
                                        input logic [CNT_W-1:0] lim,
                                        input logic             comp);
    if (comp) return (cnt < lim);
    else      return (cnt != CNT_TOP);
  endfunction

  // Output grew: compressed side larger than source side.
  function automatic logic grew(input logic [CNT_W-1:0] comp_cnt,
                                input logic [CNT_W-1:0] src_cnt);
    return (comp_cnt > src_cnt);
  endfunction

  function automatic logic [DATA_W-1:0] pack_status(input logic busy,
                                                    input logic expn,
                                                    input logic anyerr,
                                                    input logic done);
    return {busy, 3'b000, expn, 1'b0, anyerr, done};
  endfunction

endpackage

// File: rtl/xsu_ctrl.sv
module xsu_ctrl
  import xsu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst_i,
  input  logic             start_i,
  input  logic             comp_mode_i,
  input  logic [CNT_W-1:0] xfer_len_i,
  input  logic             byte_i,
  input  logic             job_end_i,
  input  logic [CNT_W-1:0] comp_cnt_i,
  input  logic             err_any_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             exp_o,
  output logic             comp_o,
  output logic [CNT_W-1:0] len_o,
  output logic             cnt_clr_o,
  output logic             cnt_step_o
);

  typedef enum logic [1:0] {EV_NONE, EV_START, EV_ABORT, EV_FINISH} ev_t;

  ev_t  ev;
  logic busy_q, done_q, exp_q, comp_q;
  logic [CNT_W-1:0] len_q;

  // Event priority: start over error over end.
  always_comb begin
    if (start_i)                    ev = EV_START;
    else if (busy_q && err_any_i)   ev = EV_ABORT;
    else if (busy_q && job_end_i)   ev = EV_FINISH;
    else                            ev = EV_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      exp_q  <= 1'b0;
      comp_q <= 1'b0;
      len_q  <= '0;
    end else if (soft_rst_i) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      exp_q  <= 1'b0;
      comp_q <= 1'b0;
      len_q  <= '0;
    end else begin
      unique case (ev)
        EV_START: begin
          busy_q <= 1'b1;
          done_q <= 1'b0;
          exp_q  <= 1'b0;
          comp_q <= comp_mode_i;
          len_q  <= xfer_len_i;
        end
        EV_ABORT: begin
          busy_q <= 1'b0;
        end
        EV_FINISH: begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          exp_q  <= comp_q && grew(comp_cnt_i, cnt_i);
        end
        default: ;
      endcase
    end
  end

  assign cnt_clr_o  = soft_rst_i || (ev == EV_START);
  assign cnt_step_o = (ev == EV_NONE) && busy_q && byte_i;

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign exp_o  = exp_q;
  assign comp_o = comp_q;
  assign len_o  = len_q;

endmodule

// File: rtl/xsu_counter.sv
module xsu_counter
  import xsu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic             comp_i,
  input  logic [CNT_W-1:0] len_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_len_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             room;

  assign room = cnt_has_room(cnt_q, len_i, comp_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (step_i && room)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o    = cnt_q;
  assign at_len_o = (cnt_q == len_i);

endmodule

// File: rtl/xsu_regmux.sv
module xsu_regmux
  import xsu_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              busy_i,
  input  logic              exp_i,
  input  logic              anyerr_i,
  input  logic              done_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [DATA_W-1:0] data_o
);

  localparam int NBYTE = CNT_W / DATA_W;

  logic [DATA_W-1:0] cnt_byte [NBYTE];

  // Byte 0 of this array is the most significant byte.
  for (genvar g = 0; g < NBYTE; g++) begin : g_slice
    assign cnt_byte[g] = cnt_i[CNT_W-1-g*DATA_W -: DATA_W];
  end

  always_comb begin
    unique case (addr_i)
      A_STATUS: data_o = pack_status(busy_i, exp_i, anyerr_i, done_i);
      A_REV:    data_o = REV_CODE;
      A_CNT_HI: data_o = cnt_byte[0];
      A_CNT_LO: data_o = cnt_byte[1];
      default:  data_o = '0;
    endcase
  end

endmodule

// File: rtl/xfer_stat_unit.sv
module xfer_stat_unit
  import xsu_pkg::*;
#(
  parameter int ERR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst_i,
  input  logic              start_i,
  input  logic              comp_mode_i,
  input  logic [15:0]       xfer_len_i,
  input  logic              byte_i,
  input  logic              job_end_i,
  input  logic [15:0]       comp_cnt_i,
  input  logic [ERR_W-1:0]  err_vec_i,
  input  logic [3:0]        rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              rx_full_o
);

  logic             err_any;
  logic             busy, done, expn, comp_mode;
  logic [CNT_W-1:0] len, cnt;
  logic             cnt_clr, cnt_step, at_len;

  assign err_any = |err_vec_i;

  xsu_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst_i  (soft_rst_i),
    .start_i     (start_i),
    .comp_mode_i (comp_mode_i),
    .xfer_len_i  (xfer_len_i),
    .byte_i      (byte_i),
    .job_end_i   (job_end_i),
    .comp_cnt_i  (comp_cnt_i),
    .err_any_i   (err_any),
    .cnt_i       (cnt),
    .busy_o      (busy),
    .done_o      (done),
    .exp_o       (expn),
    .comp_o      (comp_mode),
    .len_o       (len),
    .cnt_clr_o   (cnt_clr),
    .cnt_step_o  (cnt_step)
  );

  xsu_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (cnt_clr),
    .step_i   (cnt_step),
    .comp_i   (comp_mode),
    .len_i    (len),
    .cnt_o    (cnt),
    .at_len_o (at_len)
  );

  xsu_regmux u_mux (
    .addr_i   (rd_addr_i),
    .busy_i   (busy),
    .exp_i    (expn),
    .anyerr_i (err_any),
    .done_i   (done),
    .cnt_i    (cnt),
    .data_o   (rd_data_o)
  );

  assign rx_full_o = busy && comp_mode && at_len;

endmodule

// File: rtl/xsu_chk.sv
module xsu_chk
  import xsu_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             soft_rst_i,
  input logic             start_i,
  input logic             job_end_i,
  input logic             err_any,
  input logic             busy,
  input logic             done,
  input logic             expn,
  input logic             comp_mode,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] len,
  input logic [3:0]       rd_addr_i,
  input logic [7:0]       rd_data_o
);

  // R3
  start_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !soft_rst_i) |=> (busy && cnt == '0 && !done && !expn));

  // R3
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R4
  cnt_within_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && comp_mode) |-> (cnt <= len));

  // R5
  cnt_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !soft_rst_i) |=> (cnt >= $past(cnt)));

  // R6
  end_marks_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && job_end_i && !err_any && !start_i && !soft_rst_i) |=> (done && !busy));

  // R7
  err_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && err_any && !start_i && !soft_rst_i) |=> (!busy && !done && $stable(cnt)));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_i && !soft_rst_i) |=> ($stable(cnt) && $stable(done) && $stable(expn)));

  // R2
  rev_const_chk: assert property (@(posedge clk)
    (rd_addr_i == A_REV) |-> (rd_data_o == REV_CODE));

endmodule

bind xfer_stat_unit xsu_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .soft_rst_i (soft_rst_i),
  .start_i    (start_i),
  .job_end_i  (job_end_i),
  .err_any    (err_any),
  .busy       (busy),
  .done       (done),
  .expn       (expn),
  .comp_mode  (comp_mode),
  .cnt        (cnt),
  .len        (len),
  .rd_addr_i  (rd_addr_i),
  .rd_data_o  (rd_data_o)
);

// File: tb/xfer_stat_unit_bench.sv
`timescale 1ns/1ps
module xfer_stat_unit_bench;

  localparam int ERR_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst_i = 1'b0, start_i = 1'b0, comp_mode_i = 1'b0;
  logic [15:0] xfer_len_i = '0, comp_cnt_i = '0;
  logic byte_i = 1'b0, job_end_i = 1'b0;
  logic [ERR_W-1:0] err_vec_i = '0;
  logic [3:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;
  logic rx_full_o;

  int total = 0, bad = 0;
  bit finished = 0;

  // model state
  bit m_busy, m_done, m_exp, m_comp;
  bit [15:0] m_cnt, m_len;

  always #10 clk = ~clk;

  xfer_stat_unit #(.ERR_W(ERR_W)) u_xfer_stat_unit (.*);

  function automatic bit [7:0] exp_status(bit anyerr);
    bit [7:0] s = 8'h00;
    s[7] = m_busy; s[3] = m_exp; s[1] = anyerr; s[0] = m_done;
    return s;
  endfunction

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // Reads all registers combinationally, mid-cycle.
  task automatic check_all(string req);
    bit [3:0] ua;
    rd_addr_i = 4'd0; #1; chk(req, "status", {8'h0, rd_data_o}, {8'h0, exp_status(|err_vec_i)});
    rd_addr_i = 4'd1; #1; chk("R2", "revision", {8'h0, rd_data_o}, 16'h00EC);
    rd_addr_i = 4'd2; #1; chk(req, "count hi", {8'h0, rd_data_o}, {8'h0, m_cnt[15:8]});
    rd_addr_i = 4'd3; #1; chk(req, "count lo", {8'h0, rd_data_o}, {8'h0, m_cnt[7:0]});
    ua = 4'($urandom_range(4, 15));
    rd_addr_i = ua;   #1; chk("R8", "unmapped", {8'h0, rd_data_o}, 16'h0000);
    chk("R4", "rx_full", {15'h0, rx_full_o},
        {15'h0, (m_busy && m_comp && m_cnt == m_len)});
  endtask

  task automatic model_step();
    if (soft_rst_i) begin
      m_busy = 0; m_done = 0; m_exp = 0; m_comp = 0; m_cnt = 0; m_len = 0;
    end else if (start_i) begin
      m_busy = 1; m_done = 0; m_exp = 0; m_cnt = 0;
      m_len = xfer_len_i; m_comp = comp_mode_i;
    end else if (m_busy && (|err_vec_i)) begin
      m_busy = 0;
    end else if (m_busy && job_end_i) begin
      m_busy = 0; m_done = 1;
      m_exp = m_comp && (comp_cnt_i > m_cnt);
    end else if (m_busy && byte_i) begin
      if (m_comp) begin
        if (m_cnt < m_len) m_cnt++;
      end else if (m_cnt != 16'hFFFF) m_cnt++;
    end
  endtask

  // Drive at negedge, clock, update model, check after the edge.
  task automatic step(string req, bit srst, bit st, bit cm, bit [15:0] ln,
                      bit by, bit en, bit [15:0] cc, bit [ERR_W-1:0] ev, bit do_chk);
    @(negedge clk);
    soft_rst_i = srst; start_i = st; comp_mode_i = cm; xfer_len_i = ln;
    byte_i = by; job_end_i = en; comp_cnt_i = cc; err_vec_i = ev;
    @(posedge clk);
    model_step();
    #1;
    if (do_chk) check_all(req);
  endtask

  task automatic idle(string req, int n);
    for (int i = 0; i < n; i++) step(req, 0, 0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_busy = 0; m_done = 0; m_exp = 0; m_comp = 0; m_cnt = 0; m_len = 0;
    // R1: async reset state, R2 during reset
    #3; check_all("R1");
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    idle("R1", 1);

    // R3 start, R4 compression to limit and beyond
    step("R3", 0, 1, 1, 16'd3, 0, 0, 0, 0, 1);
    for (int i = 0; i < 5; i++) step("R4", 0, 0, 0, 0, 1, 0, 0, 0, 1);
    // R6 end with expansion (comp count 4 > 3)
    step("R6", 0, 0, 0, 0, 1, 1, 16'd4, 0, 1);
    // R9 idle strobes ignored
    step("R9", 0, 0, 0, 0, 1, 0, 0, 0, 1);
    step("R9", 0, 0, 0, 0, 0, 1, 16'd99, 0, 1);
    // R6 compression without expansion: equal counts
    step("R3", 0, 1, 1, 16'd2, 0, 0, 0, 0, 1);
    step("R4", 0, 0, 0, 0, 1, 0, 0, 0, 1);
    step("R4", 0, 0, 0, 0, 1, 0, 0, 0, 1);
    step("R6", 0, 0, 0, 0, 0, 1, 16'd2, 0, 1);
    // R4 zero length: full at once, bytes ignored
    step("R4", 0, 1, 1, 16'd0, 0, 0, 0, 0, 1);
    step("R4", 0, 0, 0, 0, 1, 0, 0, 0, 1);
    // R7 error aborts, any-error bit follows vector, done stays clear
    step("R7", 0, 0, 0, 0, 1, 1, 16'd9, 6'b000100, 1);
    step("R7", 0, 0, 0, 0, 0, 0, 0, 6'b100000, 1);
    // R3 start beats error in the same cycle
    step("R3", 0, 1, 0, 16'd0, 1, 1, 0, 6'b000001, 1);
    // R1 soft reset
    step("R5", 0, 0, 0, 0, 1, 0, 0, 0, 1);
    step("R1", 1, 1, 1, 16'd7, 1, 0, 0, 0, 1);
    // R6 decompression end never flags expansion
    step("R3", 0, 1, 0, 16'd0, 0, 0, 0, 0, 1);
    step("R5", 0, 0, 0, 0, 1, 0, 0, 0, 1);
    step("R6", 0, 0, 0, 0, 1, 1, 16'hFFFF, 0, 1);
    // R5 decompression saturation
    step("R3", 0, 1, 0, 16'd0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 65540; i++)
      step("R5", 0, 0, 0, 0, 1, 0, 0, 0, (i > 65530) || (i % 4096 == 0));
    step("R5", 0, 0, 0, 0, 1, 0, 0, 0, 1);
    // R8 random mix
    for (int i = 0; i < 4000; i++) begin
      bit st = ($urandom_range(0, 19) == 0);
      bit [ERR_W-1:0] ev = ($urandom_range(0, 29) == 0) ? ERR_W'($urandom) : '0;
      step("R8", ($urandom_range(0, 199) == 0), st, 1'($urandom),
           16'($urandom_range(0, 30)), 1'($urandom), ($urandom_range(0, 24) == 0),
           16'($urandom_range(0, 32)), ev, 1);
    end
    idle("R9", 2);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule